// File: doc/BRIEF.md
# Smartcard Character Transmitter with Retry

This block sends bytes to a smartcard over a shared, open-drain style I/O line. Bytes are written into a small internal buffer with a valid/ready handshake. Each byte goes out as one character of ten bits: a low start bit, the eight data bits with the least significant bit first, and an even parity bit. The character is followed by one or two stop periods of released line. All bit timing comes from an external pulse, `half_tick`, which fires twice per elementary time unit (ETU).

When retries are enabled, the transmitter looks at the line half an ETU into the first stop period. A card that saw a parity error holds the line low at that point. The transmitter then waits, sends the same byte again, and keeps doing so until a programmed limit is reached. If the card still complains after the last allowed resend, the byte is dropped and a sticky error flag is raised. The retry limit is programmed as the limit minus one, together with a separate enable bit. The limit field only accepts a new value while the enable is off.

Top module: `sc_char_tx`

## Requirements
- R1: A character starts only on a `half_tick`. On the line it is a 0 start bit, then data bits 0 through 7, then a parity bit equal to the XOR of the data bits, so the ten-bit frame has an even number of ones. Each bit lasts exactly two `half_tick` intervals.
- R2: `io_drive_low` is 1 only during the start bit and during data or parity bits whose value is 0. In the stop periods, in the wait before a resend, and while idle, the line is released.
- R3: `tx_done` is a one-cycle pulse. It comes 20+2S `half_tick`s after the start of the successful character, where S is 2 when `two_stop`=1 and 1 when `two_stop`=0.
- R4: With the retry enable at 0, a low `io_sense` during the stop period has no effect: the byte is sent once, `tx_done` pulses and `tx_err` stays 0.
- R5: With the retry enable at 1, the line is sampled one `half_tick` into the first stop period. A low `io_sense` there makes the block resend the same byte. The resend's start bit begins 27 `half_tick`s after the start of the character that was refused.
- R6: The retry limit L equals `cfg_retry_field`+1, giving 1 to 8. For k refusals, a byte is sent min(k,L)+1 times. If k>L, `tx_err` is set, the byte is dropped and no `tx_done` is given; otherwise `tx_done` pulses once.
- R7: A `cfg_wr` pulse always loads the retry enable from `cfg_retry_en`. It loads the limit field from `cfg_retry_field` only if the stored enable was 0 before the write; otherwise the field keeps its old value.
- R8: `tx_err` stays at 1 until `err_clr` is pulsed, and then returns to 0.
- R9: The buffer holds DEPTH bytes (default 2). `tx_ready` is 0 while it is full, a byte is taken when `tx_valid` and `tx_ready` are both 1, and bytes go out in the order they were accepted.
- R10: After reset the line is released, `tx_ready` is 1, and `tx_done` and `tx_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| half_tick | input | 1 | One-cycle pulse, two per ETU |
| tx_data | input | 8 | Byte to send |
| tx_valid | input | 1 | Byte on `tx_data` is valid |
| tx_ready | output | 1 | Buffer can accept a byte |
| two_stop | input | 1 | 1: two stop ETUs, 0: one |
| cfg_wr | input | 1 | Write strobe for the retry settings |
| cfg_retry_en | input | 1 | Retry enable value to write |
| cfg_retry_field | input | 3 | Retry limit minus one to write |
| err_clr | input | 1 | Clears the sticky error flag |
| io_sense | input | 1 | Level seen on the shared I/O line |
| io_drive_low | output | 1 | 1 pulls the I/O line low |
| tx_done | output | 1 | Pulse when a byte has been accepted by the card |
| tx_err | output | 1 | Sticky flag: byte dropped after the retries ran out |

## Verification
Random bytes are sent back to back with one and with two stop ETUs. Recovering each byte from the line separates bit order and parity faults from faults in the stop length and in the timing of `tx_done`. Directed cases send one byte with refusal counts below, at and above the limit, including the largest limit of 8 and the case where retries are disabled. The number of starts, their spacing, `tx_done` and `tx_err` together show where the attempt counting or the sampling goes wrong. A write of a new limit while retries are enabled must not change how many resends occur. A burst that fills the buffer during a character checks `tx_ready` and the order of the bytes.

// File: rtl/sc_char_tx.sv
module sc_char_tx #(
  parameter int DEPTH      = 2,
  parameter int FIELD_W    = 3,
  parameter int RECOV_HALF = 6
)(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               half_tick,
  input  logic [7:0]         tx_data,
  input  logic               tx_valid,
  output logic               tx_ready,
  input  logic               two_stop,
  input  logic               cfg_wr,
  input  logic               cfg_retry_en,
  input  logic [FIELD_W-1:0] cfg_retry_field,
  input  logic               err_clr,
  input  logic               io_sense,
  output logic               io_drive_low,
  output logic               tx_done,
  output logic               tx_err
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam int HW = $clog2(RECOV_HALF + 4);
  localparam int RW = FIELD_W + 1;

  typedef enum logic [1:0] {S_IDLE, S_BITS, S_STOP, S_RECOV} state_t;

  state_t             state;
  logic [7:0]         mem [DEPTH];
  logic [PW-1:0]      wr_ptr, rd_ptr;
  logic [CW-1:0]      count;
  logic               push, pop;
  logic [1:0]         sense_sync;
  logic               retry_en;
  logic [FIELD_W-1:0] retry_field;
  logic [RW-1:0]      retries, limit;
  logic [7:0]         cur;
  logic [3:0]         bit_idx;
  logic               phase;
  logic [HW-1:0]      hcnt, stop_last;
  logic               line_bit;

  function automatic logic [PW-1:0] next_ptr(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign tx_ready  = (count != CW'(DEPTH));
  assign push      = tx_valid && tx_ready;
  assign pop       = (state == S_IDLE) && half_tick && (count != '0);
  assign limit     = RW'(retry_field) + RW'(1);
  assign stop_last = two_stop ? HW'(3) : HW'(1);

  always_ff @(posedge clk)
    if (push) mem[wr_ptr] <= tx_data;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= next_ptr(wr_ptr);
      if (pop)  rd_ptr <= next_ptr(rd_ptr);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sense_sync <= 2'b11;
    else        sense_sync <= {sense_sync[0], io_sense};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      retry_en    <= 1'b0;
      retry_field <= '0;
    end else if (cfg_wr) begin
      retry_en <= cfg_retry_en;
      if (!retry_en) retry_field <= cfg_retry_field;
    end

  always_comb begin
    line_bit = 1'b1;
    if (bit_idx == 4'd0)      line_bit = 1'b0;
    else if (bit_idx == 4'd9) line_bit = ^cur;
    else
      for (int i = 0; i < 8; i++)
        if (bit_idx == 4'(i + 1)) line_bit = cur[i];
  end

  assign io_drive_low = (state == S_BITS) && !line_bit;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state   <= S_IDLE;
      cur     <= '0;
      bit_idx <= '0;
      phase   <= 1'b0;
      hcnt    <= '0;
      retries <= '0;
      tx_done <= 1'b0;
      tx_err  <= 1'b0;
    end else begin
      tx_done <= 1'b0;
      if (err_clr) tx_err <= 1'b0;
      if (half_tick) begin
        case (state)
          S_IDLE:
            if (count != '0) begin
              cur     <= mem[rd_ptr];
              state   <= S_BITS;
              bit_idx <= '0;
              phase   <= 1'b0;
              retries <= '0;
            end
          S_BITS:
            if (phase) begin
              phase <= 1'b0;
              if (bit_idx == 4'd9) begin
                state <= S_STOP;
                hcnt  <= '0;
              end else begin
                bit_idx <= bit_idx + 4'd1;
              end
            end else begin
              phase <= 1'b1;
            end
          S_STOP: begin
            hcnt <= hcnt + 1'b1;
            if (hcnt == '0 && retry_en && !sense_sync[1]) begin
              if (retries < limit) begin
                retries <= retries + 1'b1;
                state   <= S_RECOV;
                hcnt    <= '0;
              end else begin
                tx_err <= 1'b1;
                state  <= S_IDLE;
              end
            end else if (hcnt == stop_last) begin
              tx_done <= 1'b1;
              state   <= S_IDLE;
            end
          end
          S_RECOV:
            if (hcnt == HW'(RECOV_HALF - 1)) begin
              state   <= S_BITS;
              bit_idx <= '0;
              phase   <= 1'b0;
            end else begin
              hcnt <= hcnt + 1'b1;
            end
          default: state <= S_IDLE;
        endcase
      end
    end
endmodule

// File: rtl/sc_char_tx_chk.sv
module sc_char_tx_chk #(
  parameter int DEPTH = 2
)(
  input logic                       clk,
  input logic                       rst_n,
  input logic                       half_tick,
  input logic                       io_drive_low,
  input logic                       tx_done,
  input logic                       tx_err,
  input logic                       err_clr,
  input logic [$clog2(DEPTH+1)-1:0] count
);
  p_line_on_tick_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(io_drive_low) |-> $past(half_tick));

  p_done_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |=> !tx_done);

  p_done_on_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |-> $past(half_tick));

  p_err_without_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_err) |-> !tx_done);

  p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_err && !err_clr) |=> tx_err);

  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    count <= ($clog2(DEPTH+1))'(DEPTH));
endmodule

bind sc_char_tx sc_char_tx_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .half_tick(half_tick), .io_drive_low(io_drive_low),
  .tx_done(tx_done), .tx_err(tx_err), .err_clr(err_clr), .count(count)
);

// File: tb/sc_char_tx_test.sv
module sc_char_tx_test;
  localparam int DIVN = 4;

  logic clk = 1'b0, rst_n = 1'b0, half_tick = 1'b0;
  logic tx_valid = 1'b0, two_stop = 1'b0, cfg_wr = 1'b0, cfg_retry_en = 1'b0;
  logic err_clr = 1'b0, card_low = 1'b0;
  logic [7:0] tx_data = '0;
  logic [2:0] cfg_retry_field = '0;
  logic io_sense, tx_ready, io_drive_low, tx_done, tx_err;

  assign io_sense = !(io_drive_low || card_low);
  always #10 clk = ~clk;

  sc_char_tx uut (
    .clk(clk), .rst_n(rst_n), .half_tick(half_tick), .tx_data(tx_data),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .two_stop(two_stop),
    .cfg_wr(cfg_wr), .cfg_retry_en(cfg_retry_en), .cfg_retry_field(cfg_retry_field),
    .err_clr(err_clr), .io_sense(io_sense), .io_drive_low(io_drive_low),
    .tx_done(tx_done), .tx_err(tx_err)
  );

  int n_tests = 0, n_fail = 0;
  int gtk = 0, div = 0, fm_t = 0, card_t = 0, nack_left = 0, done_cnt = 0;
  bit fm_act = 1'b0, finished = 1'b0, consumed;
  logic [9:0] fm_bits = '0;
  logic [7:0] cap_q[$];
  int start_q[$];

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int exp_frames(input int k, input int lim);
    if (lim == 0) return 1;
    return (k <= lim) ? k + 1 : lim + 1;
  endfunction

  function automatic bit exp_err(input int k, input int lim);
    return (lim != 0) && (k > lim);
  endfunction

  function automatic bit even_ok(input logic [9:0] f);
    return (f[0] == 1'b0) && (^f[9:1] == 1'b0);
  endfunction

  always @(negedge clk) begin
    consumed = half_tick;
    if (rst_n) begin
      if (consumed) gtk++;
      if (card_low && consumed) begin
        card_t++;
        if (card_t == 2) card_low = 1'b0;
      end
      if (!fm_act) begin
        if (io_drive_low) begin
          fm_act = 1'b1;
          fm_t = 0;
          fm_bits = '0;
          start_q.push_back(gtk);
        end
      end else if (consumed) begin
        fm_t++;
        if ((fm_t % 2) == 1 && fm_t <= 19) fm_bits[(fm_t - 1) / 2] = !io_drive_low;
        if (fm_t == 20) begin
          fm_act = 1'b0;
          check(even_ok(fm_bits), "R1 start/parity", int'(fm_bits), 0);
          check(!io_drive_low, "R2 line released in stop", int'(io_drive_low), 0);
          cap_q.push_back(fm_bits[8:1]);
          if (nack_left > 0) begin
            nack_left--;
            card_low = 1'b1;
            card_t = 0;
          end
        end
      end
      if (tx_done) begin
        done_cnt++;
        if (start_q.size() > 0)
          check(gtk - start_q[start_q.size()-1] == 20 + (two_stop ? 4 : 2), "R3 done timing",
                gtk - start_q[start_q.size()-1], 20 + (two_stop ? 4 : 2));
      end
    end
    div = (div == DIVN - 1) ? 0 : div + 1;
    half_tick = (div == DIVN - 1);
  end

  task automatic send_byte(input logic [7:0] b);
    @(negedge clk);
    while (!tx_ready) @(negedge clk);
    tx_data = b;
    tx_valid = 1'b1;
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic wait_frames(input int n, input int guard);
    int g = 0;
    while (cap_q.size() < n && g < guard) begin
      @(negedge clk);
      g++;
    end
    repeat (120) @(negedge clk);
  endtask

  task automatic set_retry(input logic en, input logic [2:0] field);
    @(negedge clk);
    cfg_wr = 1'b1;
    cfg_retry_en = en;
    cfg_retry_field = field;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic new_case();
    cap_q.delete();
    start_q.delete();
    done_cnt = 0;
    nack_left = 0;
  endtask

  task automatic retry_case(input logic [7:0] b, input int nack, input int lim, input string tag);
    int ef;
    bit ee;
    new_case();
    nack_left = nack;
    ef = exp_frames(nack, lim);
    ee = exp_err(nack, lim);
    send_byte(b);
    wait_frames(ef, 4000);
    check(start_q.size() == ef, {tag, " attempts"}, start_q.size(), ef);
    foreach (cap_q[i]) check(cap_q[i] == b, {tag, " resent byte"}, int'(cap_q[i]), int'(b));
    check(done_cnt == (ee ? 0 : 1), {tag, " done count"}, done_cnt, ee ? 0 : 1);
    check(tx_err == ee, {tag, " error flag"}, int'(tx_err), int'(ee));
    if (ef >= 2 && start_q.size() >= 2)
      check(start_q[1] - start_q[0] == 27, "R5 resend spacing", start_q[1] - start_q[0], 27);
    if (tx_err) begin
      repeat (40) @(negedge clk);
      check(tx_err == 1'b1, "R8 error held", int'(tx_err), 1);
      err_clr = 1'b1;
      @(negedge clk);
      err_clr = 1'b0;
      @(negedge clk);
      check(tx_err == 1'b0, "R8 error cleared", int'(tx_err), 0);
    end
    nack_left = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] exp_q[$];
    void'($urandom(32'h5C1A0042));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(io_drive_low == 1'b0, "R10 line released", int'(io_drive_low), 0);
    check(tx_ready == 1'b1, "R10 ready", int'(tx_ready), 1);
    check(tx_err == 1'b0, "R10 error clear", int'(tx_err), 0);
    check(tx_done == 1'b0, "R10 done low", int'(tx_done), 0);

    for (int bt = 0; bt < 3; bt++) begin
      two_stop = (bt == 0) ? 1'b0 : (bt == 1) ? 1'b1 : 1'($urandom % 2);
      new_case();
      exp_q.delete();
      for (int i = 0; i < 12; i++) begin
        logic [7:0] b;
        b = (i == 0) ? 8'h00 : (i == 1) ? 8'hFF : 8'($urandom);
        exp_q.push_back(b);
        send_byte(b);
      end
      wait_frames(12, 12000);
      check(cap_q.size() == 12, "R1 frame count", cap_q.size(), 12);
      foreach (exp_q[i])
        if (i < cap_q.size())
          check(cap_q[i] == exp_q[i], "R1 R9 byte order", int'(cap_q[i]), int'(exp_q[i]));
      check(done_cnt == 12, "R3 done per byte", done_cnt, 12);
    end

    two_stop = 1'b1;
    set_retry(1'b0, 3'd0);
    retry_case(8'hA5, 1, 0, "R4 disabled");

    set_retry(1'b1, 3'd1);
    retry_case(8'h3C, 1, 2, "R5 one refusal");
    retry_case(8'h00, 2, 2, "R6 at limit");
    retry_case(8'hFF, 3, 2, "R6 over limit");

    set_retry(1'b1, 3'd5);
    retry_case(8'h81, 3, 2, "R7 write ignored");

    set_retry(1'b0, 3'd0);
    set_retry(1'b1, 3'd7);
    retry_case(8'h5A, 8, 8, "R6 limit eight");
    retry_case(8'h96, 9, 8, "R6 limit eight over");

    for (int i = 0; i < 5; i++) begin
      int lim, nk;
      lim = 1 + int'($urandom % 4);
      nk = int'($urandom % 6);
      two_stop = 1'($urandom % 2);
      set_retry(1'b0, 3'd0);
      set_retry(1'b1, 3'(lim - 1));
      retry_case(8'($urandom), nk, lim, "R6 random");
    end

    set_retry(1'b0, 3'd0);
    two_stop = 1'b0;
    new_case();
    send_byte(8'h11);
    while (start_q.size() == 0) @(negedge clk);
    send_byte(8'h22);
    send_byte(8'h33);
    check(tx_ready == 1'b0, "R9 ready low when full", int'(tx_ready), 0);
    send_byte(8'h44);
    wait_frames(4, 4000);
    check(cap_q.size() == 4, "R9 frame count", cap_q.size(), 4);
    for (int i = 0; i < 4; i++)
      if (i < cap_q.size())
        check(cap_q[i] == 8'(8'h11 * (i + 1)), "R9 order", int'(cap_q[i]), (i + 1) * 17);

    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule